// File: doc/BRIEF.md
# Stepped Setpoint Ramp Sequencer

This block controls one output channel of a multi-rail step-down regulator. It moves the digital setpoint that feeds the channel's reference DAC from its present value to a programmed goal. Each move is a fixed increment, and moves are spaced by a fixed number of clock cycles, so the output ramps instead of jumping. The setpoint is held in 100 mV units. A 4-bit voltage code picks a regulation goal between 7.5 V and 13.1 V. The all-ones code instead asks for pass-through, where the setpoint climbs past the regulation range to 15.0 V and the switch is held fully on.

The block also produces the switch-enable signal and a status byte. The status byte is zero only when the channel has sat at its goal for a settle window. It is nonzero while the setpoint is moving, while the channel is off, during an overcurrent hiccup, and during a thermal fault. The inputs that stop the channel are a global enable pin, a forced-bypass pin, an undervoltage reset, an overcurrent event and a thermal fault. Each of them is handled in the same way: while one is present the setpoint is forced to zero, and once all are clear the channel starts again from zero. All control and status pins are plain level or single-cycle pulse signals. There is no streaming data path.

Top module: `setpoint_ramp_seq`

## Requirements
- R1: The goal in 100 mV units is 75 + 4×code for codes 0x0 to 0xE, so code 0 gives 75 and code 0xE gives 131.
- R2: While running, the setpoint moves toward the goal by 2 units per step, up or down. Steps are STEP_CYCLES clock cycles apart. The first step lands STEP_CYCLES edges after the edge that starts the channel. A final step that would overshoot lands exactly on the goal.
- R3: Code 0xF sets the goal to 150 units. `full_on` is high only while the setpoint is 150 and the switch is enabled.
- R4: Status bits are: bit0 channel not running, bit1 setpoint differs from goal, bit2 overcurrent hiccup, bit3 thermal fault, bit4 not yet settled. The byte is zero only after the setpoint has equalled the goal for SETTLE_CYCLES consecutive clock edges.
- R5: A channel that was never turned on, or was turned off by `cmd_off`, has setpoint 0, `sw_en` low and status bit0 set.
- R6: When `en_pin` goes low, the setpoint is 0 one edge later and `sw_en` is low. The stored code is kept, so when `en_pin` returns high the channel ramps to the same goal.
- R7: With `en_pin` high, `byp_pin` makes the goal 150 regardless of the code, and the channel runs even if it was never turned on.
- R8: An `oc_evt` pulse while the switch is enabled drops `sw_en` for exactly HICCUP_CYCLES cycles and zeroes the setpoint. Afterwards the ramp restarts from zero.
- R9: While `ot_flt` is high, the setpoint is 0, `sw_en` is low and the status is nonzero. After it clears, the channel returns to its goal.
- R10: `uv_rst` clears the stored code and the turned-on state and zeroes the setpoint one edge later. It takes priority over `cmd_on` and `cmd_off`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock derived from the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uv_rst | input | 1 | Undervoltage reset: clears targets and setpoint |
| code | input | 4 | Voltage code, captured on `cmd_on` |
| cmd_on | input | 1 | One-cycle pulse: store `code` and turn the channel on |
| cmd_off | input | 1 | One-cycle pulse: turn the channel off |
| en_pin | input | 1 | Global enable level |
| byp_pin | input | 1 | Forced bypass level: goal becomes full-on |
| oc_evt | input | 1 | Overcurrent event pulse |
| ot_flt | input | 1 | Thermal fault level |
| setpoint | output | 8 | Setpoint in 100 mV units |
| full_on | output | 1 | Switch held fully on (pass-through reached) |
| sw_en | output | 1 | Switching allowed |
| status | output | 8 | Channel status byte, zero when ready |

## Verification
The ramp is tried from zero to an odd goal. This shows both the 2-unit stride and the single-unit landing step, and the bench checks the exact cycle of the first step. Goal changes are tried upward to a higher code, downward to a lower code, and upward to pass-through. This separates a correct two-direction stepper from one that only climbs, and confirms that `full_on` is reached. Each shutdown cause is applied on its own: enable low, disable command, thermal fault, overcurrent and undervoltage. The follow-up ramp then shows which causes keep the stored target and which clear it. The hiccup length and the settle window are measured to the exact cycle.

// File: rtl/ramp_seq_pkg.sv
package ramp_seq_pkg;
  localparam int SP_W    = 8;
  localparam int CODE_W  = 4;
  localparam int BASE_U  = 75;
  localparam int PITCH_U = 4;
  localparam int FULL_U  = 150;
  localparam int STEP_U  = 2;
  localparam int ST_OFF  = 0;
  localparam int ST_MOVE = 1;
  localparam int ST_HIC  = 2;
  localparam int ST_OT   = 3;
  localparam int ST_SETL = 4;
endpackage

// File: rtl/ramp_tick.sv
module ramp_tick #(
  parameter int PERIOD = 384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (clr)         cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = !clr && (cnt == LAST);
endmodule

// File: rtl/ramp_goal.sv
module ramp_goal
  import ramp_seq_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              force_full,
  output logic [SP_W-1:0]   goal
);
  logic [SP_W-1:0] scaled;

  always_comb begin
    scaled = SP_W'(code) * SP_W'(PITCH_U);
    if (force_full || (code == {CODE_W{1'b1}})) goal = SP_W'(FULL_U);
    else                                        goal = SP_W'(BASE_U) + scaled;
  end
endmodule

// File: rtl/ramp_window.sv
module ramp_window #(
  parameter int LEN = 1104
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic done
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] TOP = CW'(LEN);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (restart)    cnt <= '0;
    else if (cnt != TOP) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == TOP);
endmodule

// File: rtl/ramp_hiccup.sv
module ramp_hiccup #(
  parameter int LEN = 750000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic trig,
  output logic active
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(LEN);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (clr)       cnt <= '0;
    else if (trig)      cnt <= LOAD;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);
endmodule

// File: rtl/setpoint_ramp_seq.sv
module setpoint_ramp_seq
  import ramp_seq_pkg::*;
#(
  parameter int STEP_CYCLES   = 384,
  parameter int SETTLE_CYCLES = 1104,
  parameter int HICCUP_CYCLES = 750000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uv_rst,
  input  logic [CODE_W-1:0] code,
  input  logic              cmd_on,
  input  logic              cmd_off,
  input  logic              en_pin,
  input  logic              byp_pin,
  input  logic              oc_evt,
  input  logic              ot_flt,
  output logic [SP_W-1:0]   setpoint,
  output logic              full_on,
  output logic              sw_en,
  output logic [7:0]        status
);
  localparam logic [SP_W-1:0] STEP = SP_W'(STEP_U);
  localparam logic [SP_W-1:0] FULL = SP_W'(FULL_U);

  logic [CODE_W-1:0] code_q;
  logic              ch_on;
  logic [SP_W-1:0]   sp_q;
  logic [SP_W-1:0]   goal;
  logic              run, hold, tick, hic_act, settled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      ch_on  <= 1'b0;
    end else if (uv_rst) begin
      code_q <= '0;
      ch_on  <= 1'b0;
    end else if (cmd_on) begin
      code_q <= code;
      ch_on  <= 1'b1;
    end else if (cmd_off) begin
      ch_on  <= 1'b0;
    end
  end

  assign run  = en_pin && (ch_on || byp_pin);
  assign hold = !run || ot_flt || hic_act;

  ramp_goal u_goal (
    .code       (code_q),
    .force_full (byp_pin),
    .goal       (goal)
  );

  ramp_tick #(.PERIOD(STEP_CYCLES)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (hold || uv_rst),
    .tick  (tick)
  );

  ramp_hiccup #(.LEN(HICCUP_CYCLES)) u_hic (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (uv_rst),
    .trig   (oc_evt && !hold),
    .active (hic_act)
  );

  ramp_window #(.LEN(SETTLE_CYCLES)) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (hold || uv_rst || (sp_q != goal)),
    .done    (settled)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               sp_q <= '0;
    else if (uv_rst || hold)  sp_q <= '0;
    else if (tick) begin
      if (sp_q < goal)        sp_q <= ((goal - sp_q) > STEP) ? sp_q + STEP : goal;
      else if (sp_q > goal)   sp_q <= ((sp_q - goal) > STEP) ? sp_q - STEP : goal;
    end
  end

  always_comb begin
    status          = '0;
    status[ST_OFF]  = !run;
    status[ST_MOVE] = (sp_q != goal);
    status[ST_HIC]  = hic_act;
    status[ST_OT]   = ot_flt;
    status[ST_SETL] = !settled;
  end

  assign setpoint = sp_q;
  assign sw_en    = !hold;
  assign full_on  = !hold && (sp_q == FULL);
endmodule

// File: rtl/setpoint_ramp_seq_chk.sv
module setpoint_ramp_seq_chk
  import ramp_seq_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            uv_rst,
  input logic            oc_evt,
  input logic [SP_W-1:0] setpoint,
  input logic            full_on,
  input logic            sw_en,
  input logic [7:0]      status
);
  // R2: consecutive enabled samples differ by at most one step
  a_r2_step_size: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && $past(sw_en)) |->
      ((setpoint >= $past(setpoint)) ? ((setpoint - $past(setpoint)) <= SP_W'(STEP_U))
                                     : (($past(setpoint) - setpoint) <= SP_W'(STEP_U))));

  // R3: full-on only while switching is allowed
  a_r3_full_on_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    full_on |-> sw_en);

  // R4: a ready channel has a steady setpoint
  a_r4_ready_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 8'h00) |-> $stable(setpoint));

  // R5: once switching is off the setpoint is zero next cycle
  a_r5_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |=> (setpoint == '0));

  // R8: an overcurrent while switching stops the switch next cycle
  a_r8_hiccup_start: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_evt && sw_en && !uv_rst) |=> (!sw_en && status != 8'h00));

  // R10: undervoltage reset zeroes the setpoint and leaves a not-ready status
  a_r10_uv_clear: assert property (@(posedge clk) disable iff (!rst_n)
    uv_rst |=> (setpoint == '0 && status != 8'h00));
endmodule

bind setpoint_ramp_seq setpoint_ramp_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .uv_rst   (uv_rst),
  .oc_evt   (oc_evt),
  .setpoint (setpoint),
  .full_on  (full_on),
  .sw_en    (sw_en),
  .status   (status)
);

// File: tb/setpoint_ramp_seq_tb.sv
module setpoint_ramp_seq_tb;
  localparam int STEP   = 4;
  localparam int SETTLE = 6;
  localparam int HIC    = 30;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       uv_rst = 1'b0;
  logic [3:0] code = 4'h0;
  logic       cmd_on = 1'b0;
  logic       cmd_off = 1'b0;
  logic       en_pin = 1'b1;
  logic       byp_pin = 1'b0;
  logic       oc_evt = 1'b0;
  logic       ot_flt = 1'b0;
  logic [7:0] setpoint;
  logic       full_on;
  logic       sw_en;
  logic [7:0] status;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  setpoint_ramp_seq #(
    .STEP_CYCLES(STEP), .SETTLE_CYCLES(SETTLE), .HICCUP_CYCLES(HIC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .uv_rst(uv_rst), .code(code),
    .cmd_on(cmd_on), .cmd_off(cmd_off), .en_pin(en_pin), .byp_pin(byp_pin),
    .oc_evt(oc_evt), .ot_flt(ot_flt), .setpoint(setpoint), .full_on(full_on),
    .sw_en(sw_en), .status(status)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cy(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_on(input logic [3:0] c);
    @(negedge clk);
    code = c;
    cmd_on = 1'b1;
    @(negedge clk);
    cmd_on = 1'b0;
  endtask

  task automatic t_reset();
    chk(setpoint == 8'd0, "R5 reset setpoint", setpoint, 0);
    chk(sw_en == 1'b0, "R5 reset sw_en", sw_en, 0);
    chk(status[0] == 1'b1, "R5 reset status off bit", status, 1);
    chk(full_on == 1'b0, "R3 reset full_on", full_on, 0);
  endtask

  task automatic t_ramp_up();
    int bad = 0;
    logic [7:0] prev;
    send_on(4'h0);
    wait_cy(STEP - 1);
    chk(setpoint == 8'd0, "R2 before first step", setpoint, 0);
    wait_cy(1);
    chk(setpoint == 8'd2, "R2 first step cycle", setpoint, 2);
    chk(status != 8'h00, "R4 moving status", status, 1);
    prev = setpoint;
    for (int i = 0; i < 400 && setpoint != 8'd75; i++) begin
      @(negedge clk);
      if (!(setpoint == prev || setpoint == prev + 8'd2 ||
            (setpoint == 8'd75 && setpoint == prev + 8'd1))) bad++;
      prev = setpoint;
    end
    chk(bad == 0, "R2 step stride", bad, 0);
    chk(setpoint == 8'd75, "R1 code 0 goal", setpoint, 75);
    chk(status != 8'h00, "R4 arrival not ready", status, 1);
    wait_cy(SETTLE - 1);
    chk(status != 8'h00, "R4 settle window not over", status, 1);
    wait_cy(1);
    chk(status == 8'h00, "R4 settled ready", status, 0);
  endtask

  task automatic t_code_change();
    send_on(4'hE);
    wait_cy(200);
    chk(setpoint == 8'd131, "R1 code E goal", setpoint, 131);
    chk(status == 8'h00, "R4 ready at 131", status, 0);
    send_on(4'h3);
    wait_cy(150);
    chk(setpoint == 8'd87, "R2 step down to 87", setpoint, 87);
    send_on(4'h0);
    wait_cy(100);
    chk(setpoint == 8'd75, "R2 step down to 75", setpoint, 75);
  endtask

  task automatic t_pass_code();
    send_on(4'hF);
    chk(full_on == 1'b0, "R3 no full_on while ramping", full_on, 0);
    wait_cy(250);
    chk(setpoint == 8'd150, "R3 pass-through setpoint", setpoint, 150);
    chk(full_on == 1'b1, "R3 full_on", full_on, 1);
    chk(status == 8'h00, "R4 ready at full-on", status, 0);
  endtask

  task automatic t_en_low();
    @(negedge clk);
    en_pin = 1'b0;
    @(negedge clk);
    chk(setpoint == 8'd0, "R6 enable low zero", setpoint, 0);
    chk(sw_en == 1'b0, "R6 enable low sw_en", sw_en, 0);
    chk(status != 8'h00, "R6 enable low status", status, 1);
    en_pin = 1'b1;
    wait_cy(400);
    chk(setpoint == 8'd150, "R6 target kept", setpoint, 150);
  endtask

  task automatic t_overcurrent();
    send_on(4'h0);
    wait_cy(300);
    chk(setpoint == 8'd75, "R8 pre-fault level", setpoint, 75);
    @(negedge clk);
    oc_evt = 1'b1;
    @(negedge clk);
    oc_evt = 1'b0;
    chk(sw_en == 1'b0, "R8 hiccup start", sw_en, 0);
    chk(status[2] == 1'b1, "R8 hiccup status bit", status, 4);
    wait_cy(HIC - 1);
    chk(sw_en == 1'b0, "R8 hiccup last cycle", sw_en, 0);
    chk(setpoint == 8'd0, "R8 setpoint zero in hiccup", setpoint, 0);
    wait_cy(1);
    chk(sw_en == 1'b1, "R8 hiccup end", sw_en, 1);
    wait_cy(300);
    chk(setpoint == 8'd75, "R8 resumed ramp", setpoint, 75);
  endtask

  task automatic t_overtemp();
    @(negedge clk);
    ot_flt = 1'b1;
    @(negedge clk);
    chk(setpoint == 8'd0, "R9 thermal zero", setpoint, 0);
    chk(sw_en == 1'b0, "R9 thermal sw_en", sw_en, 0);
    chk(status[3] == 1'b1, "R9 thermal status bit", status, 8);
    ot_flt = 1'b0;
    wait_cy(300);
    chk(setpoint == 8'd75, "R9 thermal recovery", setpoint, 75);
    chk(status == 8'h00, "R9 ready after thermal", status, 0);
  endtask

  task automatic t_disable();
    @(negedge clk);
    cmd_off = 1'b1;
    @(negedge clk);
    cmd_off = 1'b0;
    @(negedge clk);
    chk(setpoint == 8'd0, "R5 disabled zero", setpoint, 0);
    chk(status[0] == 1'b1, "R5 disabled status", status, 1);
    wait_cy(50);
    chk(setpoint == 8'd0, "R5 disabled stays zero", setpoint, 0);
  endtask

  task automatic t_forced_bypass();
    @(negedge clk);
    byp_pin = 1'b1;
    wait_cy(400);
    chk(setpoint == 8'd150, "R7 forced bypass level", setpoint, 150);
    chk(full_on == 1'b1, "R7 forced bypass full_on", full_on, 1);
    byp_pin = 1'b0;
    @(negedge clk);
    chk(setpoint == 8'd0, "R7 bypass release on off channel", setpoint, 0);
  endtask

  task automatic t_undervoltage();
    send_on(4'h2);
    wait_cy(250);
    chk(setpoint == 8'd83, "R1 code 2 goal", setpoint, 83);
    @(negedge clk);
    uv_rst = 1'b1;
    cmd_on = 1'b1;
    code = 4'h5;
    @(negedge clk);
    uv_rst = 1'b0;
    cmd_on = 1'b0;
    chk(setpoint == 8'd0, "R10 undervoltage zero", setpoint, 0);
    wait_cy(300);
    chk(setpoint == 8'd0, "R10 targets cleared", setpoint, 0);
    chk(status[0] == 1'b1, "R10 channel off after uv", status, 1);
  endtask

  initial begin
    wait_cy(3);
    rst_n = 1'b1;
    @(negedge clk);
    en_pin = 1'b1;
    t_reset();
    t_ramp_up();
    t_code_change();
    t_pass_code();
    t_en_low();
    t_overcurrent();
    t_overtemp();
    t_disable();
    t_forced_bypass();
    t_undervoltage();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule